// File: doc/BRIEF.md
# Multiplexed LED PWM intensity controller

This block keeps the brightness settings for a multiplexed LED matrix driver. Each digit has its own 8-bit intensity register, and one global configuration register applies to the whole driver. The driver visits the digits one after another in slots of 256 clock cycles. In each slot, the enable bit for the active digit is high for n of the 256 cycles, where n is that digit's intensity.

A panel holds many of these drivers, and their combined supply current would peak at the same moment if they all switched together. Two features spread that current out. The first is a start delay of four clocks per position. It uses a static driver index and is enabled by a configuration bit. The second is a time-reversed PWM waveform on drivers that sit at odd positions, enabled by another configuration bit. A host writes the registers and reads them back through a plain address/data port. Read data is registered, so it appears one cycle after the address.

Top module: `led_pwm_ctrl`

## Requirements
- R1: The configuration register is at address 0x01 and the intensity register of digit k is at address 0x03+k. `rd_data` shows the register selected by `addr` one cycle later. An unmapped address reads 0x00.
- R2: Slots last 256 cycles and visit the digits in order 0, 1, ... and then wrap. In the normal form, `pwm_out[k]` is high for the first n counts of digit k's slot. Only the bit of the active digit can be high.
- R3: When configuration bit 5 is 1 and `odd_pos` is 1, the on-time moves to the last n counts of the slot. When `odd_pos` is 0, the waveform keeps its normal form.
- R4: Writing configuration bit 4 from 0 to 1 stops the slot sequence and restarts it after `drv_index`×4 clocks. The first enable then appears 4×`drv_index`+2 cycles after the write edge.
- R5: Configuration bits 3:2 read back the `active_plane` input. Values written to those bits are ignored.
- R6: Configuration bit 6 stores the colour mode. With `FORCE_MONO`=1 it always reads 0 and writes to it are ignored.
- R7: After reset, every register reads 0 and `pwm_out` is all zero.
- R8: A write to an intensity register takes effect only at the next slot boundary.
- R9: An intensity of 255 gives 255 high cycles per 256-cycle slot, and an intensity of 0 gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| active_plane | input | 2 | Currently displayed memory plane, reported in config bits 3:2 |
| drv_index | input | IDX_W | Static position of this driver in the chain |
| odd_pos | input | 1 | Static: driver sits at an odd position |
| pwm_out | output | NUM_DIGITS | Per-digit PWM enable, registered |

## Verification
The assertions assume that `drv_index` and `odd_pos` are static while the sequence runs. They also assume that intensity values fit in 8 bits, which means the never-fully-on rule at the slot edge holds for every legal value. The stimulus sets both position inputs before reset releases and never changes them afterwards. All register traffic uses the documented addresses, plus one unmapped read. The bench model follows the slot counter, the start delay and the latched level cycle by cycle. It therefore checks writes that land mid-slot and the restart that follows enabling the delay.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam int          DATA_W    = 8;
  localparam int          SLOT_LEN  = 256;
  localparam logic [7:0]  CFG_ADDR  = 8'h01;
  localparam logic [7:0]  DIG_BASE  = 8'h03;
  localparam int          PLANE_LO  = 2;
  localparam int          RIPPLE_B  = 4;
  localparam int          FLIP_B    = 5;
  localparam int          COLOR_B   = 6;

  typedef struct packed {
    logic color;
    logic flip;
    logic ripple;
  } cfg_t;
endpackage

// File: rtl/led_regfile.sv
module led_regfile
  import led_pwm_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter bit FORCE_MONO = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [7:0]                   addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [1:0]                   active_plane,
  output logic [DATA_W-1:0]            rd_data,
  output cfg_t                         cfg,
  output logic [NUM_DIGITS*DATA_W-1:0] inten,
  output logic                         ripple_arm
);
  logic [DATA_W-1:0] level_mem [NUM_DIGITS];
  logic              cfg_hit;
  logic [DATA_W-1:0] rd_next;

  assign cfg_hit    = (addr == CFG_ADDR);
  assign ripple_arm = wr_en && cfg_hit && wr_data[RIPPLE_B] && !cfg.ripple;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    always_ff @(posedge clk) begin
      if (rst)
        level_mem[g] <= '0;
      else if (wr_en && addr == DIG_BASE + 8'(g))
        level_mem[g] <= wr_data;
    end
    assign inten[g*DATA_W +: DATA_W] = level_mem[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.ripple <= 1'b0;
      cfg.flip   <= 1'b0;
    end else if (wr_en && cfg_hit) begin
      cfg.ripple <= wr_data[RIPPLE_B];
      cfg.flip   <= wr_data[FLIP_B];
    end
  end

  if (FORCE_MONO) begin : g_mono
    assign cfg.color = 1'b0;
  end else begin : g_color
    always_ff @(posedge clk) begin
      if (rst)
        cfg.color <= 1'b0;
      else if (wr_en && cfg_hit)
        cfg.color <= wr_data[COLOR_B];
    end
  end

  always_comb begin
    rd_next = '0;
    if (cfg_hit) begin
      rd_next[COLOR_B]              = cfg.color;
      rd_next[FLIP_B]               = cfg.flip;
      rd_next[RIPPLE_B]             = cfg.ripple;
      rd_next[PLANE_LO+1:PLANE_LO]  = active_plane;
    end
    for (int i = 0; i < NUM_DIGITS; i++)
      if (addr == DIG_BASE + 8'(i)) rd_next = level_mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R5: plane field follows the input, never the written data
  a_r5_plane_readonly: assert property (@(posedge clk) disable iff (rst)
    cfg_hit |=> rd_data[PLANE_LO+1:PLANE_LO] == $past(active_plane));

  // R6: forced monocolour never reports colour mode
  a_r6_mono_forced: assert property (@(posedge clk) disable iff (rst)
    FORCE_MONO |-> !cfg.color);

  // R7: registers read zero right after reset
  a_r7_rd_reset: assert property (@(posedge clk)
    rst |=> rd_data == '0);
endmodule

// File: rtl/led_ripple_start.sv
module led_ripple_start #(
  parameter int IDX_W = 8,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ripple_en,
  input  logic             restart,
  input  logic [IDX_W-1:0] drv_index,
  output logic             running
);
  localparam int WAIT_W = IDX_W + $clog2(STEP) + 1;

  logic [WAIT_W-1:0] wait_cnt;
  logic [WAIT_W-1:0] target;

  assign target = WAIT_W'(drv_index) * WAIT_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      running  <= 1'b0;
      wait_cnt <= '0;
    end else if (!running) begin
      if (!ripple_en || wait_cnt == target)
        running <= 1'b1;
      else
        wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R4: sequence stays stopped until the stagger has elapsed
  a_r4_hold_delay: assert property (@(posedge clk) disable iff (rst)
    (!running && ripple_en && wait_cnt != target) |=> !running);

  // R4: enabling the stagger always stops the sequence
  a_r4_restart_stops: assert property (@(posedge clk) disable iff (rst)
    restart |=> !running);
endmodule

// File: rtl/led_slot_pwm.sv
module led_slot_pwm
  import led_pwm_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         running,
  input  logic                         reverse,
  input  logic [NUM_DIGITS*DATA_W-1:0] inten,
  output logic [NUM_DIGITS-1:0]        pwm_out
);
  localparam int DIG_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int CNT_W = $clog2(SLOT_LEN);

  logic [CNT_W-1:0]  cnt;
  logic [DIG_W-1:0]  dig, dig_nxt;
  logic [DATA_W-1:0] level;
  logic              on_now;

  assign dig_nxt = (dig == DIG_W'(NUM_DIGITS-1)) ? '0 : dig + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dig   <= '0;
      level <= '0;
    end else if (!running) begin
      cnt   <= '0;
      dig   <= '0;
      level <= inten[0 +: DATA_W];
    end else if (cnt == CNT_W'(SLOT_LEN-1)) begin
      cnt   <= '0;
      dig   <= dig_nxt;
      level <= inten[dig_nxt*DATA_W +: DATA_W];
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (reverse)
      on_now = {1'b0, cnt} >= (9'(SLOT_LEN) - {1'b0, level});
    else
      on_now = cnt < level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= '0;
    end else begin
      pwm_out <= '0;
      if (running && on_now) pwm_out[dig] <= 1'b1;
    end
  end

  // R2: at most one digit is enabled
  a_r2_one_digit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pwm_out));

  // R9: normal form is dark on the final count of every slot
  a_r9_tail_dark: assert property (@(posedge clk) disable iff (rst)
    (running && !reverse && cnt == CNT_W'(SLOT_LEN-1)) |=> pwm_out == '0);

  // R9: reversed form is dark on the first count of every slot
  a_r9_head_dark: assert property (@(posedge clk) disable iff (rst)
    (running && reverse && cnt == '0) |=> pwm_out == '0);

  // R8: latched level only moves at a slot boundary or while stopped
  a_r8_level_held: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != CNT_W'(SLOT_LEN-1)) |=> $stable(level));

  // R7: outputs dark right after reset
  a_r7_pwm_reset: assert property (@(posedge clk)
    rst |=> pwm_out == '0);
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
  import led_pwm_pkg::*;
#(
  parameter int NUM_DIGITS  = 2,
  parameter int IDX_W       = 8,
  parameter int RIPPLE_STEP = 4,
  parameter bit FORCE_MONO  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  input  logic [1:0]            active_plane,
  input  logic [IDX_W-1:0]      drv_index,
  input  logic                  odd_pos,
  output logic [NUM_DIGITS-1:0] pwm_out
);
  cfg_t                         cfg;
  logic [NUM_DIGITS*DATA_W-1:0] inten;
  logic                         ripple_arm;
  logic                         running;

  led_regfile #(.NUM_DIGITS(NUM_DIGITS), .FORCE_MONO(FORCE_MONO)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .active_plane(active_plane), .rd_data(rd_data), .cfg(cfg),
    .inten(inten), .ripple_arm(ripple_arm)
  );

  led_ripple_start #(.IDX_W(IDX_W), .STEP(RIPPLE_STEP)) u_start (
    .clk(clk), .rst(rst), .ripple_en(cfg.ripple), .restart(ripple_arm),
    .drv_index(drv_index), .running(running)
  );

  led_slot_pwm #(.NUM_DIGITS(NUM_DIGITS)) u_slot (
    .clk(clk), .rst(rst), .running(running),
    .reverse(cfg.flip && odd_pos), .inten(inten), .pwm_out(pwm_out)
  );
endmodule

// File: tb/led_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module led_pwm_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] active_plane = 2'b00;
  logic [7:0] drv_index = 8'd3;
  logic       odd_pos = 1'b1;
  logic [7:0] rd_data, rd_mono;
  logic [1:0] pwm_out, pwm_mono;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  led_pwm_ctrl u_led_pwm_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .active_plane(active_plane), .drv_index(drv_index),
    .odd_pos(odd_pos), .pwm_out(pwm_out)
  );

  led_pwm_ctrl #(.FORCE_MONO(1'b1)) u_mono (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_mono), .active_plane(active_plane), .drv_index(drv_index),
    .odd_pos(odd_pos), .pwm_out(pwm_mono)
  );

  // behavioural reference model, advanced on every rising edge
  int   m_int [2];
  bit   m_rip, m_flip, m_col, m_run;
  int   m_wait, m_pos, m_dig, m_lvl;
  logic [1:0] e_pwm;
  logic [7:0] e_rd;

  always @(posedge clk) begin
    bit rv;
    bit lit;
    if (rst) begin
      m_int[0] = 0; m_int[1] = 0;
      m_rip = 0; m_flip = 0; m_col = 0; m_run = 0;
      m_wait = 0; m_pos = 0; m_dig = 0; m_lvl = 0;
      e_pwm = 2'b00; e_rd = 8'h00;
    end else begin
      rv  = m_flip && odd_pos;
      lit = rv ? (m_pos >= 256 - m_lvl) : (m_pos < m_lvl);
      e_pwm = 2'b00;
      if (m_run && lit) e_pwm[m_dig] = 1'b1;
      if (addr == 8'h01)
        e_rd = {1'b0, m_col, m_flip, m_rip, active_plane, 2'b00};
      else if (addr == 8'h03 || addr == 8'h04)
        e_rd = 8'(m_int[addr - 8'h03]);
      else
        e_rd = 8'h00;
      if (!m_run) begin
        m_pos = 0; m_dig = 0; m_lvl = m_int[0];
      end else if (m_pos == 255) begin
        m_pos = 0; m_dig = (m_dig + 1) % 2; m_lvl = m_int[m_dig];
      end else begin
        m_pos = m_pos + 1;
      end
      if (wr_en && addr == 8'h01 && wr_data[4] && !m_rip) begin
        m_run = 0; m_wait = 0;
      end else if (!m_run) begin
        if (!m_rip || m_wait == 4 * int'(drv_index)) m_run = 1;
        else m_wait = m_wait + 1;
      end
      if (wr_en) begin
        if (addr == 8'h01) begin
          m_rip = wr_data[4]; m_flip = wr_data[5]; m_col = wr_data[6];
        end
        if (addr == 8'h03) m_int[0] = int'(wr_data);
        if (addr == 8'h04) m_int[1] = int'(wr_data);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if (pwm_out !== e_pwm) begin
      errors++;
      $display("FAIL R2/R3/R8 pwm_out actual=%b expected=%b at %0t", pwm_out, e_pwm, $time);
    end
    checks++;
    if (rd_data !== e_rd) begin
      errors++;
      $display("FAIL R1 rd_data actual=%h expected=%h at %0t", rd_data, e_rd, $time);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output int v, output int vm);
    @(negedge clk); addr = a;
    @(negedge clk); v = int'(rd_data); vm = int'(rd_mono);
    addr = 8'h00;
  endtask

  task automatic count_high(input int d, output int n);
    n = 0;
    repeat (512) begin
      @(negedge clk);
      if (pwm_out[d]) n++;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, vm, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check("R7 pwm after reset", int'(pwm_out), 0);
    rd(8'h01, v, vm); check("R7 cfg after reset", v, 0);
    rd(8'h03, v, vm); check("R7 digit0 after reset", v, 0);

    wr(8'h03, 8'd255);
    wr(8'h04, 8'd0);
    rd(8'h03, v, vm); check("R1 digit0 readback", v, 255);
    rd(8'h04, v, vm); check("R1 digit1 readback", v, 0);
    rd(8'h07, v, vm); check("R1 unmapped read", v, 0);
    repeat (1100) @(negedge clk);
    count_high(0, n); check("R9 level 255 on-time", n, 255);
    count_high(1, n); check("R9 level 0 on-time", n, 0);

    wr(8'h03, 8'd128);
    repeat (100) @(negedge clk);
    wr(8'h04, 8'd64);
    repeat (1100) @(negedge clk);
    count_high(0, n); check("R2 level 128 on-time", n, 128);
    count_high(1, n); check("R2 level 64 on-time", n, 64);

    active_plane = 2'b10;
    wr(8'h01, 8'h2C);
    rd(8'h01, v, vm); check("R5 plane bits read-only", v, 8'h28);
    repeat (1100) @(negedge clk);
    count_high(0, n); check("R3 reversed level 128", n, 128);
    count_high(1, n); check("R3 reversed level 64", n, 64);

    wr(8'h01, 8'h60);
    rd(8'h01, v, vm);
    check("R6 colour bit stored", v, 8'h68);
    check("R6 colour forced mono", vm, 8'h28);

    wr(8'h01, 8'h00);
    repeat (600) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h01; wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
    n = 0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (pwm_out[0] && n == 0) n = k;
    end
    check("R4 ripple start delay", n, 4 * int'(drv_index) + 2);

    repeat (300) @(negedge clk);
    wr(8'h03, 8'd10);
    repeat (700) @(negedge clk);
    count_high(0, n); check("R8 new level applied", n, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule